// File: doc/BRIEF.md
# SPI Flash Read and Identification Responder

This block is the read side of a serial flash slave on an SPI bus. A master selects it with an active-low chip select and sends an 8-bit opcode, most significant bit first. The block can return bytes from its internal byte array (plain read, or fast read with one dummy byte), an identification string, or a one-byte signature. It also supports a deep power-down state, in which it answers only the release opcode. The master may use clock polarity/phase 0,0 or 1,1 without telling the block which.

All serial signals are oversampled by the system clock `clk_i`. The byte array resets to FFh in every location. The program/erase engine, which is outside this block, writes the array through a write port and reports its running cycles on `busy_i`. The read address is `MEM_AW` bits wide. It steps by one per data byte and wraps from the top location back to zero for as long as chip select stays low.

Top module: `sflash_rd_resp`

## Requirements
- R1: Input bits are taken on rising serial-clock edges, MSB first. Output bits change only after falling serial-clock edges. Idle clock level 0 (mode 0) and idle level 1 (mode 3) both work.
- R2: `miso_oe_o` is 0 whenever `cs_ni` is high and 1 whenever `cs_ni` is low.
- R3: Opcode 03h followed by three address bytes returns the array byte at that address in the next byte slot, then the bytes at successive addresses.
- R4: Opcode 0Bh followed by three address bytes and one ignored dummy byte returns the array bytes from that address onward.
- R5: Address bits 23 down to `MEM_AW` are ignored. After location 2^MEM_AW-1 the read continues at location 0.
- R6: Opcode 9Fh returns 20h, 20h, 14h, then a length byte 10h, then the 16 bytes of `UID_DATA` taking bits 127:120 first, then 00h for every further byte.
- R7: Opcode B9h enters deep power-down only if chip select rises after exactly 8 clocks. With any extra clock the opcode is discarded.
- R8: A B9h opcode is rejected if `busy_i` is high when chip select rises.
- R9: In deep power-down every opcode other than ABh is ignored, and the output reads 00h for the whole transfer.
- R10: Opcode ABh returns the byte 13h repeatedly and leaves deep power-down. When the block is not powered down, ABh also returns 13h.
- R11: After reset every array byte reads FFh and the block is not powered down.
- R12: A cycle with `wr_en_i` high stores `wr_data_i` at `wr_addr_i`. Later reads return the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master |
| cs_ni | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data from the master |
| busy_i | input | 1 | Program/erase/write cycle running elsewhere |
| wr_en_i | input | 1 | Array write strobe from the program path |
| wr_addr_i | input | MEM_AW | Array write address |
| wr_data_i | input | 8 | Array write data |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for miso_o; 0 means high impedance |

## Verification
Serial edges reach the core three system clocks after they occur at the pins. An output bit therefore appears about 30 ns after the falling serial-clock edge that launches it. The bench runs the serial clock with 60 ns half periods and reads `miso_o` just before each rising edge. This gives every output bit a full half period to settle after its launch edge. Chip select acts on the output enable with no delay, and the bench checks the enable a whole half period after moving chip select. The power-down cases are judged only by the transfer that follows, so each decision is observed after it has been committed at deselect.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_DUMMY, PH_READ, PH_ID, PH_SIG, PH_DPARM, PH_SKIP
  } phase_e;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FAST  = 8'h0B;
  localparam logic [7:0] OP_ID    = 8'h9F;
  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] OP_WAKE  = 8'hAB;

  localparam logic [7:0] ID_MFR   = 8'h20;
  localparam logic [7:0] ID_TYPE  = 8'h20;
  localparam logic [7:0] ID_CAP   = 8'h14;
  localparam logic [7:0] ID_LEN   = 8'h10;
  localparam logic [7:0] SIG_BYTE = 8'h13;
endpackage

// File: rtl/sflash_sync.sv
module sflash_sync #(
  parameter int          N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] prev_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [2:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {3{RST_VAL[g]}};
      else         chain_q <= {chain_q[1:0], async_i[g]};
    end
    assign sync_o[g] = chain_q[1];
    assign prev_o[g] = chain_q[2];
  end
endmodule

// File: rtl/sflash_byte_array.sv
module sflash_byte_array #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sflash_id_rom.sv
module sflash_id_rom import sflash_pkg::*; #(
  parameter int           IDX_W    = 5,
  parameter logic [127:0] UID_DATA = '0
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o
);
  always_comb begin
    int k;
    k = int'(idx_i);
    byte_o = 8'h00;
    if (k == 0)      byte_o = ID_MFR;
    else if (k == 1) byte_o = ID_TYPE;
    else if (k == 2) byte_o = ID_CAP;
    else if (k == 3) byte_o = ID_LEN;
    else if (k < 20) byte_o = UID_DATA[8*(19-k) +: 8];
  end
endmodule

// File: rtl/sflash_rd_resp.sv
module sflash_rd_resp import sflash_pkg::*; #(
  parameter int           MEM_AW   = 8,
  parameter logic [127:0] UID_DATA = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  input  logic              busy_i,
  input  logic              wr_en_i,
  input  logic [MEM_AW-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              miso_o,
  output logic              miso_oe_o
);
  localparam int IDX_W   = 5;
  localparam int ID_LAST = 20;

  logic [2:0] sync_s, sync_p;
  logic sck_rise, sck_fall, cs_hi, cs_rise, mosi_s;

  sflash_sync #(.N(3), .RST_VAL(3'b010)) u_sync (
    .clk_i, .rst_ni,
    .async_i({mosi_i, cs_ni, sck_i}),
    .sync_o (sync_s),
    .prev_o (sync_p)
  );

  assign sck_rise = sync_s[0] & ~sync_p[0];
  assign sck_fall = ~sync_s[0] & sync_p[0];
  assign cs_hi    = sync_s[1];
  assign cs_rise  = sync_s[1] & ~sync_p[1];
  assign mosi_s   = sync_s[2];

  phase_e            phase_q;
  logic [2:0]        bit_cnt_q;
  logic [7:0]        rx_q;
  logic [1:0]        abyte_q;
  logic              dummy_q;
  logic [15:0]       acc_q;
  logic [MEM_AW-1:0] addr_q;
  logic [7:0]        tx_q;
  logic              miso_q;
  logic              dp_q;
  logic [IDX_W-1:0]  id_idx_q;

  logic [7:0]        rx_next;
  logic              byte_done;
  logic [23:0]       addr_cat;
  logic [MEM_AW-1:0] addr_new, rd_addr;
  logic [7:0]        mem_byte, id_byte;

  assign rx_next   = {rx_q[6:0], mosi_s};
  assign byte_done = sck_rise & (bit_cnt_q == 3'd7) & ~cs_hi;
  assign addr_cat  = {acc_q, rx_next};
  assign addr_new  = addr_cat[MEM_AW-1:0];
  assign rd_addr   = (phase_q == PH_ADDR) ? addr_new : addr_q;

  sflash_byte_array #(.AW(MEM_AW)) u_array (
    .clk_i, .rst_ni,
    .we_i   (wr_en_i),
    .waddr_i(wr_addr_i),
    .wdata_i(wr_data_i),
    .raddr_i(rd_addr),
    .rdata_o(mem_byte)
  );

  sflash_id_rom #(.IDX_W(IDX_W), .UID_DATA(UID_DATA)) u_id (
    .idx_i (id_idx_q),
    .byte_o(id_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_CMD;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      abyte_q   <= '0;
      dummy_q   <= 1'b0;
      acc_q     <= '0;
      addr_q    <= '0;
      tx_q      <= '0;
      miso_q    <= 1'b0;
      dp_q      <= 1'b0;
      id_idx_q  <= '0;
    end else if (cs_hi) begin
      // power-down commits only on a clean 8-clock deselect
      if (cs_rise && phase_q == PH_DPARM && bit_cnt_q == 3'd0 && !busy_i)
        dp_q <= 1'b1;
      phase_q   <= PH_CMD;
      bit_cnt_q <= '0;
      abyte_q   <= '0;
      tx_q      <= '0;
      miso_q    <= 1'b0;
      id_idx_q  <= '0;
    end else begin
      if (sck_fall) miso_q <= tx_q[3'd7 - bit_cnt_q];
      if (sck_rise) begin
        rx_q      <= rx_next;
        bit_cnt_q <= bit_cnt_q + 3'd1;
        if (phase_q == PH_DPARM) phase_q <= PH_SKIP;
      end
      if (byte_done) begin
        unique case (phase_q)
          PH_CMD: begin
            if (dp_q) begin
              if (rx_next == OP_WAKE) begin
                dp_q    <= 1'b0;
                tx_q    <= SIG_BYTE;
                phase_q <= PH_SIG;
              end else begin
                phase_q <= PH_SKIP;
              end
            end else begin
              unique case (rx_next)
                OP_READ: begin phase_q <= PH_ADDR; dummy_q <= 1'b0; end
                OP_FAST: begin phase_q <= PH_ADDR; dummy_q <= 1'b1; end
                OP_ID: begin
                  tx_q     <= ID_MFR;
                  id_idx_q <= IDX_W'(1);
                  phase_q  <= PH_ID;
                end
                OP_WAKE: begin tx_q <= SIG_BYTE; phase_q <= PH_SIG; end
                OP_SLEEP: phase_q <= PH_DPARM;
                default:  phase_q <= PH_SKIP;
              endcase
            end
          end
          PH_ADDR: begin
            acc_q   <= addr_cat[15:0];
            abyte_q <= abyte_q + 2'd1;
            if (abyte_q == 2'd2) begin
              if (dummy_q) begin
                addr_q  <= addr_new;
                phase_q <= PH_DUMMY;
              end else begin
                tx_q    <= mem_byte;
                addr_q  <= addr_new + 1'b1;
                phase_q <= PH_READ;
              end
            end
          end
          PH_DUMMY, PH_READ: begin
            tx_q    <= mem_byte;
            addr_q  <= addr_q + 1'b1;
            phase_q <= PH_READ;
          end
          PH_ID: begin
            tx_q <= id_byte;
            if (id_idx_q != IDX_W'(ID_LAST)) id_idx_q <= id_idx_q + 1'b1;
          end
          PH_SIG:  tx_q <= SIG_BYTE;
          default: ;
        endcase
      end
    end
  end

  assign miso_o    = miso_q;
  assign miso_oe_o = ~cs_ni;
endmodule

// File: rtl/sflash_rd_resp_chk.sv
module sflash_rd_resp_chk import sflash_pkg::*; #(
  parameter int MEM_AW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              cs_hi,
  input logic              cs_rise,
  input logic              sck_rise,
  input logic              sck_fall,
  input logic              dp_q,
  input phase_e            phase_q,
  input logic [2:0]        bit_cnt_q,
  input logic [MEM_AW-1:0] addr_q,
  input logic [7:0]        rx_next,
  input logic              miso_o
);
  logic done_w;
  logic [MEM_AW-1:0] one_w;
  assign done_w = sck_rise && bit_cnt_q == 3'd7 && !cs_hi;
  assign one_w  = {{(MEM_AW-1){1'b0}}, 1'b1};

  AST_DP_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dp_q) |-> $past(!busy_i && cs_rise)); // R8
  AST_DP_EIGHT_CLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dp_q) |-> $past(phase_q == PH_DPARM && bit_cnt_q == 3'd0)); // R7
  AST_WAKE_VIA_SIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dp_q) |-> phase_q == PH_SIG); // R10
  AST_DP_GATES_OPCODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_q && done_w && phase_q == PH_CMD && rx_next != OP_WAKE) |=> phase_q == PH_SKIP); // R9
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_READ && done_w) |=> addr_q == $past(addr_q) + one_w); // R5
  AST_MISO_FALL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_fall && !cs_hi) |=> $stable(miso_o)); // R1
endmodule

bind sflash_rd_resp sflash_rd_resp_chk #(.MEM_AW(MEM_AW)) u_chk (.*);

// File: tb/sflash_rd_resp_tb_top.sv
`timescale 1ns/1ps
module sflash_rd_resp_tb_top;
  localparam int AW   = 8;
  localparam int HALF = 60;
  localparam logic [127:0] UID = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

  // {mode3, opcode, address, bytes to read}
  localparam logic [40:0] VEC [8] = '{
    {1'b0, 8'h03, 24'h000010, 8'd4},  // R3
    {1'b1, 8'h03, 24'h0000FE, 8'd4},  // R5 wrap, R1 mode 3
    {1'b0, 8'h03, 24'hF5A020, 8'd3},  // R5 upper bits ignored
    {1'b1, 8'h0B, 24'h000040, 8'd3},  // R4
    {1'b0, 8'h0B, 24'h0000FF, 8'd2},  // R4 with wrap
    {1'b0, 8'h9F, 24'h000000, 8'd22}, // R6 incl. trailing 00h
    {1'b1, 8'h9F, 24'h000000, 8'd5},  // R6 mode 3
    {1'b1, 8'hAB, 24'h000000, 8'd3}   // R10 while awake
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, busy = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic miso, miso_oe;
  int n_chk = 0, n_fail = 0;
  logic [7:0] rx_buf [32];

  always #5 clk = ~clk;

  sflash_rd_resp #(.MEM_AW(AW), .UID_DATA(UID)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .busy_i(busy), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .miso_o(miso), .miso_oe_o(miso_oe)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a % 256) * 7 + 3);
  endfunction

  function automatic logic [7:0] id_exp(input int k);
    if (k == 0 || k == 1) return 8'h20;
    if (k == 2) return 8'h14;
    if (k == 3) return 8'h10;
    if (k < 20) return UID[8*(19-k) +: 8];
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic put_bit(input logic v, output logic got);
    sck = 1'b0; mosi = v; #(HALF);
    got = miso; sck = 1'b1; #(HALF);
  endtask

  task automatic xfer(input logic m3, input logic [7:0] op, input logic [23:0] adr,
                      input int nhdr, input int nrd);
    logic g;
    logic [7:0] b;
    @(negedge clk);
    sck = m3; #(HALF);
    cs_n = 1'b0; #(HALF);
    for (int i = 7; i >= 0; i--) put_bit(op[i], g);
    if (nhdr >= 3) for (int i = 23; i >= 0; i--) put_bit(adr[i], g);
    if (nhdr == 4) for (int i = 7; i >= 0; i--) put_bit(1'b0, g);
    for (int k = 0; k < nrd; k++) begin
      b = '0;
      for (int i = 7; i >= 0; i--) begin put_bit(1'b0, g); b = {b[6:0], g}; end
      rx_buf[k] = b;
    end
    if (!m3) sck = 1'b0;
    #(HALF);
    cs_n = 1'b1; #(2*HALF);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(10 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    #23 rst_n = 1'b1;
    #40;
    chk("R2 deselected oe", {7'd0, miso_oe}, 8'h00);

    // R11: array erased after reset
    xfer(1'b0, 8'h03, 24'h000005, 3, 2);
    chk("R11 erased byte0", rx_buf[0], 8'hFF);
    chk("R11 erased byte1", rx_buf[1], 8'hFF);

    for (int a = 0; a < 256; a++) wr(a, pat(a));

    // R12: write then read back
    wr(8'h33, 8'hA5);
    xfer(1'b1, 8'h03, 24'h000033, 3, 1);
    chk("R12 written byte", rx_buf[0], 8'hA5);
    wr(8'h33, pat(8'h33));

    foreach (VEC[v]) begin
      logic m3; logic [7:0] op, n; logic [23:0] ad; int nh;
      {m3, op, ad, n} = VEC[v];
      nh = (op == 8'h03) ? 3 : (op == 8'h0B) ? 4 : 0;
      xfer(m3, op, ad, nh, int'(n));
      for (int k = 0; k < int'(n); k++) begin
        if (op == 8'h03)      chk("R3/R5/R1 read",  rx_buf[k], pat(int'(ad[7:0]) + k));
        else if (op == 8'h0B) chk("R4 fast read",   rx_buf[k], pat(int'(ad[7:0]) + k));
        else if (op == 8'h9F) chk("R6 id",          rx_buf[k], id_exp(k));
        else                  chk("R10 signature",  rx_buf[k], 8'h13);
      end
    end

    // R2: enable follows select
    @(negedge clk); cs_n = 1'b0; #(HALF);
    chk("R2 selected oe", {7'd0, miso_oe}, 8'h01);
    cs_n = 1'b1; #(HALF);
    chk("R2 released oe", {7'd0, miso_oe}, 8'h00);

    // R7/R9/R10: sleep, ignored reads, wake
    xfer(1'b0, 8'hB9, 24'h0, 0, 0);
    xfer(1'b0, 8'h03, 24'h000010, 3, 2);
    chk("R9 read while asleep", rx_buf[0], 8'h00);
    chk("R9 read while asleep", rx_buf[1], 8'h00);
    xfer(1'b1, 8'h9F, 24'h0, 0, 2);
    chk("R9 id while asleep", rx_buf[0], 8'h00);
    xfer(1'b1, 8'hAB, 24'h0, 0, 2);
    chk("R10 wake signature", rx_buf[0], 8'h13);
    chk("R10 wake signature", rx_buf[1], 8'h13);
    xfer(1'b0, 8'h03, 24'h000010, 3, 2);
    chk("R10 read after wake", rx_buf[0], pat(16));
    chk("R10 read after wake", rx_buf[1], pat(17));

    // R7: an extra byte of clocks cancels power-down
    xfer(1'b0, 8'hB9, 24'h0, 0, 1);
    xfer(1'b0, 8'h03, 24'h000020, 3, 1);
    chk("R7 cancelled sleep", rx_buf[0], pat(32));

    // R8: rejected while busy
    busy = 1'b1;
    xfer(1'b1, 8'hB9, 24'h0, 0, 0);
    busy = 1'b0;
    xfer(1'b1, 8'h03, 24'h000080, 3, 1);
    chk("R8 sleep rejected when busy", rx_buf[0], pat(128));

    finish_run();
  end
endmodule